// File: doc/BRIEF.md
# Receive Frame Buffer Packer

This block sits between a receive MAC and the packet RAM of a small Ethernet controller. Each incoming frame arrives as a byte stream. A start pulse carries the frame length. Data bytes follow on a valid strobe, and an end flag marks the last byte, together with the frame's CRC value. When the frame is accepted, the block takes one page from a free-page allocator. It then writes the frame into that page in a fixed layout:

- a header holding status and byte count;
- the even-length body;
- the CRC, when it is kept;
- a two-byte tail that records whether the final data byte is odd.

Once the layout is complete, the page index goes onto the receive queue and the receive interrupt is set. A frame is discarded without touching RAM, the allocator or the queue in four cases: reception is disabled, soft reset is asserted, the stored count would not fit in a page, or no page is free. Discarded frames are still consumed from the stream. A ready output stays low from the start pulse until the last byte of the layout is written, so a new frame can only begin once the previous one is fully stored.

Top module: `rx_frame_packer`

## Requirements
- R1: A frame started while `rxEnable` is 0 or `softReset` is 1 produces no RAM write, no `allocTake` and no `rxPush`.
- R2: A frame shorter than 64 bytes is stored as 64 bytes. Payload bytes, including an odd final byte, sit in place, zeros fill the rest, and the tail is 0x00 then 0x40.
- R3: The stored count equals the padded length with bit 0 cleared, plus 6, plus 4 when `stripCrc` is 0. It is written little-endian at page offsets 2 and 3. No RAM write in a frame lands at an offset at or above the count.
- R4: A frame whose count would exceed 2048 is dropped with no RAM write, allocation or push. A count of exactly 2048 is accepted.
- R5: Page offsets 0 and 1 hold a little-endian status word. Bit 11 is set when the length exceeds 1518, bit 12 is set when the length is odd, and all other bits are zero.
- R6: When `stripCrc` is 0, the four bytes of `crcIn` are written least significant first, directly after the even-length body at offset 4 + body length. When `stripCrc` is 1, no CRC bytes are stored.
- R7: For an odd frame of at least 64 bytes, the tail is the final data byte followed by 0x60. For an even frame of at least 64 bytes, the tail is 0x00 followed by 0x40.
- R8: An accepted frame causes exactly one `rxPush` with `rxPage` equal to the page taken, and exactly one `rxIrqSet`, both in the cycle of the final header write at offset 3.
- R9: With `freeValid` low at the start pulse, the frame is dropped, `allocTake` is never asserted, and RAM and the queue are untouched.
- R10: `ready` is high when idle. It is low from the cycle after a start pulse until the cycle after the push, or until the last byte of a dropped frame. No RAM write occurs while `ready` is high.
- R11: Payload byte i (i below the length with bit 0 cleared) is written to page offset 4 + i. The RAM address is the page index above an 11-bit byte offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Reception enabled, sampled at the start pulse |
| stripCrc | input | 1 | 1 = do not store the CRC, sampled at the start pulse |
| softReset | input | 1 | Soft reset active, sampled at the start pulse |
| frmStart | input | 1 | Start of a frame; honoured only while `ready` is high |
| frmLen | input | 12 | Frame length in bytes, valid with `frmStart` |
| byteValid | input | 1 | `byteData` carries the next frame byte |
| byteData | input | 8 | Frame byte |
| frmEnd | input | 1 | Marks the last byte, with `byteValid` |
| crcIn | input | 32 | Frame CRC, valid with the last byte |
| freeValid | input | 1 | Allocator has a free page |
| freePage | input | 2 | Index of the free page |
| allocTake | output | 1 | Consumes the offered free page |
| ramWe | output | 1 | Packet RAM byte write enable |
| ramAddr | output | 13 | Page index and 11-bit byte offset |
| ramData | output | 8 | Byte written to packet RAM |
| rxPush | output | 1 | Append `rxPage` to the receive queue |
| rxPage | output | 2 | Page of the completed frame |
| rxIrqSet | output | 1 | Sets the receive interrupt bit |
| ready | output | 1 | A new frame may start |

## Verification
A wrong internal count or offset shows up at once as a RAM write at the wrong address. It also surfaces a few cycles after the end flag as a wrong byte in the stored image, which the bench compares in full against an image it builds itself after every frame. A stuck phase or sub-counter shows as `ready` failing to return, or as a missing or doubled push. The bench catches this within one frame time. A wrongly taken drop decision is visible in the start cycle through `allocTake`, and over the frame through the count of RAM writes and pushes.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

  // Which part of the page layout is being written this cycle.
  typedef enum logic [2:0] {
    W_NONE,
    W_STREAM,
    W_PAD,
    W_CRC,
    W_TAIL,
    W_HDR
  } wrSel_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic       capture;  // latch frame parameters on an idle start
    logic       byteIn;   // a stream byte is present
    logic       lastIn;   // that byte is the final one
    wrSel_t     sel;      // layout region
    logic [1:0] sub;      // byte index inside CRC, tail or header
  } dpCmd_t;

  localparam int STAT_LONG_BIT = 11;
  localparam int STAT_ODD_BIT  = 12;
  localparam logic [7:0] TAIL_ODD  = 8'h60;
  localparam logic [7:0] TAIL_EVEN = 8'h40;
  localparam int HDR_BYTES = 4;
  localparam int CNT_EXTRA = 6;
  localparam int CRC_BYTES = 4;

endpackage

// File: rtl/rxpk_datapath.sv
module rxpk_datapath
  import rxpk_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 2048,
  parameter int LEN_W      = 12,
  parameter int MIN_FRAME  = 64,
  parameter int LONG_LIMIT = 1518
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpCmd_t                        cmd,
  input  logic                          rxEnable,
  input  logic                          stripCrc,
  input  logic                          softReset,
  input  logic [LEN_W-1:0]              frmLen,
  input  logic [7:0]                    byteData,
  input  logic [31:0]                   crcIn,
  input  logic                          freeValid,
  input  logic [$clog2(PAGES)-1:0]      freePage,
  output logic                          dropNow,
  output logic                          shortFrm,
  output logic                          padLast,
  output logic                          keepCrc,
  output logic                          ramWe,
  output logic [$clog2(PAGES)+$clog2(PAGE_BYTES)-1:0] ramAddr,
  output logic [7:0]                    ramData,
  output logic [$clog2(PAGES)-1:0]      curPage
);

  localparam int PAGE_W = $clog2(PAGES);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int CNT_W  = LEN_W + 1;

  // Decision made in the start cycle from live inputs.
  logic [CNT_W-1:0] startPad, startEven, startCnt;
  always_comb begin
    startPad  = (frmLen < LEN_W'(MIN_FRAME)) ? CNT_W'(MIN_FRAME) : {1'b0, frmLen};
    startEven = startPad & ~CNT_W'(1);
    startCnt  = startEven + CNT_W'(CNT_EXTRA) + (stripCrc ? CNT_W'(0) : CNT_W'(CRC_BYTES));
    dropNow   = !rxEnable || softReset || !freeValid || (startCnt > CNT_W'(PAGE_BYTES));
  end

  // Per-frame state.
  logic [LEN_W-1:0]  lenR, idx;
  logic [CNT_W-1:0]  cntR, padPtr;
  logic              keepR;
  logic [PAGE_W-1:0] pageR;
  logic [7:0]        lastByte;
  logic [31:0]       crcR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenR     <= '0;
      idx      <= '0;
      cntR     <= '0;
      padPtr   <= '0;
      keepR    <= 1'b0;
      pageR    <= '0;
      lastByte <= '0;
      crcR     <= '0;
    end else begin
      if (cmd.capture) begin
        lenR   <= frmLen;
        idx    <= '0;
        cntR   <= startCnt;
        padPtr <= CNT_W'(HDR_BYTES) + {1'b0, frmLen};
        keepR  <= !stripCrc;
        pageR  <= freePage;
      end
      if (cmd.byteIn) begin
        idx      <= idx + LEN_W'(1);
        lastByte <= byteData;
      end
      if (cmd.lastIn) crcR <= crcIn;
      if (cmd.sel == W_PAD) padPtr <= padPtr + CNT_W'(1);
    end
  end

  // Layout geometry of the captured frame.
  logic [LEN_W-1:0] lenEven;
  logic [CNT_W-1:0] bodyLen, crcBase, tailBase;
  logic             tailOdd, inPlace;
  logic [15:0]      statWord, cnt16;

  always_comb begin
    lenEven  = lenR & ~LEN_W'(1);
    shortFrm = lenR < LEN_W'(MIN_FRAME);
    bodyLen  = shortFrm ? CNT_W'(MIN_FRAME) : {1'b0, lenEven};
    crcBase  = CNT_W'(HDR_BYTES) + bodyLen;
    tailBase = crcBase + (keepR ? CNT_W'(CRC_BYTES) : CNT_W'(0));
    tailOdd  = !shortFrm && lenR[0];
    inPlace  = (idx < lenR) && (shortFrm || (idx < lenEven));
    padLast  = padPtr == CNT_W'(HDR_BYTES + MIN_FRAME - 1);
    keepCrc  = keepR;
    statWord = '0;
    statWord[STAT_ODD_BIT]  = lenR[0];
    statWord[STAT_LONG_BIT] = lenR > LEN_W'(LONG_LIMIT);
    cnt16    = 16'(cntR);
  end

  // Write port mux.
  logic [CNT_W-1:0] ofsWide;
  always_comb begin
    ramWe   = 1'b0;
    ofsWide = '0;
    ramData = '0;
    unique case (cmd.sel)
      W_STREAM: begin
        ramWe   = cmd.byteIn && inPlace;
        ofsWide = CNT_W'(HDR_BYTES) + {1'b0, idx};
        ramData = byteData;
      end
      W_PAD: begin
        ramWe   = 1'b1;
        ofsWide = padPtr;
      end
      W_CRC: begin
        ramWe   = 1'b1;
        ofsWide = crcBase + CNT_W'(cmd.sub);
        ramData = crcR[{cmd.sub, 3'b000} +: 8];
      end
      W_TAIL: begin
        ramWe   = 1'b1;
        ofsWide = tailBase + CNT_W'(cmd.sub);
        if (cmd.sub[0]) ramData = tailOdd ? TAIL_ODD : TAIL_EVEN;
        else            ramData = tailOdd ? lastByte : 8'h00;
      end
      W_HDR: begin
        ramWe   = 1'b1;
        ofsWide = CNT_W'(cmd.sub);
        case (cmd.sub)
          2'd0:    ramData = statWord[7:0];
          2'd1:    ramData = statWord[15:8];
          2'd2:    ramData = cnt16[7:0];
          default: ramData = cnt16[15:8];
        endcase
      end
      default: ;
    endcase
  end

  assign ramAddr = {pageR, ofsWide[OFS_W-1:0]};
  assign curPage = pageR;

  // R3
  wr_inside_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ofsWide < cntR));

endmodule

// File: rtl/rxpk_ctrl.sv
module rxpk_ctrl
  import rxpk_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   frmStart,
  input  logic   byteValid,
  input  logic   frmEnd,
  input  logic   dropNow,
  input  logic   shortFrm,
  input  logic   padLast,
  input  logic   keepCrc,
  output dpCmd_t cmd,
  output logic   ready,
  output logic   allocTake,
  output logic   rxPush
);

  typedef enum logic [2:0] {S_IDLE, S_SKIP, S_DATA, S_PAD, S_CRC, S_TAIL, S_HDR} st_t;

  st_t        state, stateN;
  logic [1:0] subR, subN;
  logic       lastByteIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      subR  <= '0;
    end else begin
      state <= stateN;
      subR  <= subN;
    end
  end

  assign lastByteIn = byteValid && frmEnd;

  always_comb begin
    cmd       = '0;
    cmd.sel   = W_NONE;
    cmd.sub   = subR;
    ready     = 1'b0;
    allocTake = 1'b0;
    rxPush    = 1'b0;
    stateN    = state;
    subN      = subR;
    unique case (state)
      S_IDLE: begin
        ready = 1'b1;
        subN  = '0;
        if (frmStart) begin
          cmd.capture = 1'b1;
          allocTake   = !dropNow;
          stateN      = dropNow ? S_SKIP : S_DATA;
        end
      end
      S_SKIP: if (lastByteIn) stateN = S_IDLE;
      S_DATA: begin
        cmd.sel    = W_STREAM;
        cmd.byteIn = byteValid;
        cmd.lastIn = lastByteIn;
        if (lastByteIn) begin
          subN   = '0;
          stateN = shortFrm ? S_PAD : (keepCrc ? S_CRC : S_TAIL);
        end
      end
      S_PAD: begin
        cmd.sel = W_PAD;
        if (padLast) begin
          subN   = '0;
          stateN = keepCrc ? S_CRC : S_TAIL;
        end
      end
      S_CRC: begin
        cmd.sel = W_CRC;
        subN    = subR + 2'd1;
        if (subR == 2'd3) stateN = S_TAIL;
      end
      S_TAIL: begin
        cmd.sel = W_TAIL;
        if (subR == 2'd1) begin
          subN   = '0;
          stateN = S_HDR;
        end else begin
          subN = subR + 2'd1;
        end
      end
      S_HDR: begin
        cmd.sel = W_HDR;
        subN    = subR + 2'd1;
        if (subR == 2'd3) begin
          rxPush = 1'b1;
          stateN = S_IDLE;
        end
      end
      default: stateN = S_IDLE;
    endcase
  end

  // R2
  pad_only_short_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PAD) |-> shortFrm);

endmodule

// File: rtl/rx_frame_packer.sv
module rx_frame_packer
  import rxpk_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 2048,
  parameter int LEN_W      = 12,
  parameter int MIN_FRAME  = 64,
  parameter int LONG_LIMIT = 1518
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic                                        rxEnable,
  input  logic                                        stripCrc,
  input  logic                                        softReset,
  input  logic                                        frmStart,
  input  logic [LEN_W-1:0]                            frmLen,
  input  logic                                        byteValid,
  input  logic [7:0]                                  byteData,
  input  logic                                        frmEnd,
  input  logic [31:0]                                 crcIn,
  input  logic                                        freeValid,
  input  logic [$clog2(PAGES)-1:0]                    freePage,
  output logic                                        allocTake,
  output logic                                        ramWe,
  output logic [$clog2(PAGES)+$clog2(PAGE_BYTES)-1:0] ramAddr,
  output logic [7:0]                                  ramData,
  output logic                                        rxPush,
  output logic [$clog2(PAGES)-1:0]                    rxPage,
  output logic                                        rxIrqSet,
  output logic                                        ready
);

  localparam int OFS_W = $clog2(PAGE_BYTES);

  dpCmd_t cmd;
  logic   dropNow, shortFrm, padLast, keepCrc;

  rxpk_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .frmStart(frmStart), .byteValid(byteValid),
    .frmEnd(frmEnd), .dropNow(dropNow), .shortFrm(shortFrm),
    .padLast(padLast), .keepCrc(keepCrc), .cmd(cmd), .ready(ready),
    .allocTake(allocTake), .rxPush(rxPush)
  );

  rxpk_datapath #(
    .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W),
    .MIN_FRAME(MIN_FRAME), .LONG_LIMIT(LONG_LIMIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rxEnable(rxEnable),
    .stripCrc(stripCrc), .softReset(softReset), .frmLen(frmLen),
    .byteData(byteData), .crcIn(crcIn), .freeValid(freeValid),
    .freePage(freePage), .dropNow(dropNow), .shortFrm(shortFrm),
    .padLast(padLast), .keepCrc(keepCrc), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramData(ramData), .curPage(rxPage)
  );

  assign rxIrqSet = rxPush;

  // R1
  take_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocTake |-> (rxEnable && !softReset));

  // R9
  take_needs_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocTake |-> freeValid);

  // R10
  no_write_when_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> !ready);

  // R8
  push_on_last_hdr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> (ramWe && (ramAddr[OFS_W-1:0] == OFS_W'(3))));

  // R10
  ready_after_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |=> ready);

endmodule

// File: tb/rx_frame_packer_tb_top.sv
module rx_frame_packer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxEnable = 1'b0, stripCrc = 1'b0, softReset = 1'b0;
  logic        frmStart = 1'b0;
  logic [11:0] frmLen = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        frmEnd = 1'b0;
  logic [31:0] crcIn = '0;
  logic        freeValid = 1'b0;
  logic [1:0]  freePage = '0;
  logic        allocTake, ramWe, rxPush, rxIrqSet, ready;
  logic [12:0] ramAddr;
  logic [7:0]  ramData;
  logic [1:0]  rxPage;

  always #5 clk = ~clk;

  rx_frame_packer dut_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .stripCrc(stripCrc),
    .softReset(softReset), .frmStart(frmStart), .frmLen(frmLen),
    .byteValid(byteValid), .byteData(byteData), .frmEnd(frmEnd),
    .crcIn(crcIn), .freeValid(freeValid), .freePage(freePage),
    .allocTake(allocTake), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramData(ramData), .rxPush(rxPush), .rxPage(rxPage),
    .rxIrqSet(rxIrqSet), .ready(ready)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] mem [0:8191];
  logic [7:0] pay [0:4095];
  logic [7:0] expImg [0:2047];
  int wrCount = 0, pushCount = 0, irqCount = 0, allocCount = 0;
  logic [1:0] lastPushPage = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Observe outputs mid-cycle; inputs change just after rising edges.
  always @(negedge clk) begin
    if (rstN) begin
      if (ramWe) begin
        mem[ramAddr] = ramData;
        wrCount++;
      end
      if (rxPush) begin
        pushCount++;
        lastPushPage = rxPage;
      end
      if (rxIrqSet) irqCount++;
      if (allocTake) allocCount++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Builds the expected page image; returns the stored count.
  function automatic int buildExpected(input int len, input bit keep, input logic [31:0] crc);
    int pad, body, cnt, p;
    pad  = (len < 64) ? 64 : len;
    body = pad & ~1;
    cnt  = body + 6 + (keep ? 4 : 0);
    for (int i = 0; i < 2048; i++) expImg[i] = 8'h00;
    expImg[0] = 8'h00;
    expImg[1] = ((len > 1518) ? 8'h08 : 8'h00) | (len[0] ? 8'h10 : 8'h00);
    expImg[2] = cnt[7:0];
    expImg[3] = cnt[15:8];
    for (int i = 0; i < (len & ~1); i++) expImg[4 + i] = pay[i];
    if (len < 64 && len[0]) expImg[4 + len - 1] = pay[len - 1];
    p = 4 + body;
    if (keep) begin
      for (int k = 0; k < 4; k++) expImg[p + k] = crc[8*k +: 8];
      p += 4;
    end
    if (len >= 64 && len[0]) begin
      expImg[p] = pay[len - 1];
      expImg[p + 1] = 8'h60;
    end else begin
      expImg[p] = 8'h00;
      expImg[p + 1] = 8'h40;
    end
    return cnt;
  endfunction

  task automatic sendFrame(input int len, input bit en, input bit strip, input bit srst,
                           input bit pageOk, input int page, input bit gaps, input string req);
    int cnt, w0, p0, i0, a0, spin, bad;
    logic [31:0] crc;
    bit drop;
    crc = $urandom;
    for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
    for (int i = 0; i < 2048; i++) mem[page*2048 + i] = 8'hA5;
    cnt  = buildExpected(len, !strip, crc);
    drop = !en || srst || !pageOk || (cnt > 2048);
    w0 = wrCount; p0 = pushCount; i0 = irqCount; a0 = allocCount;

    @(posedge clk); #1;
    rxEnable = en; stripCrc = strip; softReset = srst;
    freeValid = pageOk; freePage = 2'(page);
    frmStart = 1'b1; frmLen = 12'(len);
    @(posedge clk); #1;
    frmStart = 1'b0;
    // R10: busy right after the start
    chk(ready == 1'b0, "R10", "ready after start", ready, 0);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom_range(0, 7) == 0)) begin
        byteValid = 1'b0;
        @(posedge clk); #1;
      end
      byteValid = 1'b1; byteData = pay[i]; frmEnd = (i == len - 1); crcIn = crc;
      @(posedge clk); #1;
    end
    byteValid = 1'b0; frmEnd = 1'b0;
    spin = 0;
    while (!ready && spin < 200) begin
      @(posedge clk); #1;
      spin++;
    end
    chk(ready == 1'b1, "R10", "ready returns", ready, 1);

    if (drop) begin
      // R1 R4 R9: nothing touched
      chk(wrCount == w0, req, "ram writes on drop", wrCount - w0, 0);
      chk(pushCount == p0 && allocCount == a0, req, "push/alloc on drop",
          (pushCount - p0) * 16 + (allocCount - a0), 0);
    end else begin
      bad = -1;
      for (int i = 0; i < cnt; i++)
        if (bad < 0 && mem[page*2048 + i] !== expImg[i]) bad = i;
      // R2 R3 R5 R6 R7 R11: stored image
      chk(bad < 0, req, $sformatf("image len=%0d byte %0d", len, bad),
          (bad < 0) ? 0 : mem[page*2048 + bad], (bad < 0) ? 0 : expImg[bad]);
      // R3: nothing beyond the count
      chk(mem[page*2048 + cnt] === 8'hA5 || cnt == 2048, "R3", "byte past count",
          mem[page*2048 + (cnt % 2048)], 8'hA5);
      // R8: one push, one interrupt, correct page, one allocation
      chk(pushCount == p0 + 1 && irqCount == i0 + 1 && allocCount == a0 + 1, "R8",
          "push/irq/alloc counts", (pushCount - p0) * 256 + (irqCount - i0) * 16 + (allocCount - a0),
          32'h111);
      chk(lastPushPage == 2'(page), "R8", "pushed page", lastPushPage, page);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #2;
    // reset state
    chk(ready == 1'b1, "R10", "ready after reset", ready, 1);
    chk(ramWe == 1'b0 && rxPush == 1'b0 && allocTake == 1'b0 && rxIrqSet == 1'b0,
        "R10", "outputs idle after reset", {ramWe, rxPush, allocTake, rxIrqSet}, 0);

    sendFrame(10,   1, 0, 0, 1, 0, 0, "R2");   // short even, CRC kept
    sendFrame(11,   1, 1, 0, 1, 1, 0, "R2");   // short odd, stripped
    sendFrame(63,   1, 0, 0, 1, 2, 1, "R2");
    sendFrame(64,   1, 0, 0, 1, 3, 0, "R6");   // boundary, even
    sendFrame(65,   1, 0, 0, 1, 0, 0, "R7");   // odd long, 0x60 tail
    sendFrame(65,   1, 1, 0, 1, 1, 0, "R7");   // odd long, stripped
    sendFrame(100,  1, 1, 0, 1, 2, 1, "R11");
    sendFrame(1518, 1, 0, 0, 1, 3, 0, "R5");   // not long
    sendFrame(1519, 1, 1, 0, 1, 0, 0, "R5");   // long and odd
    sendFrame(2038, 1, 0, 0, 1, 1, 0, "R4");   // count exactly 2048
    sendFrame(2043, 1, 1, 0, 1, 2, 0, "R4");   // odd, count 2048
    sendFrame(2040, 1, 0, 0, 1, 3, 0, "R4");   // count 2050: drop
    sendFrame(2044, 1, 1, 0, 1, 0, 0, "R4");   // count 2050: drop
    sendFrame(80,   0, 0, 0, 1, 1, 0, "R1");   // disabled
    sendFrame(80,   1, 0, 1, 1, 2, 0, "R1");   // soft reset
    sendFrame(80,   1, 0, 0, 0, 3, 0, "R9");   // no free page
    sendFrame(70,   1, 0, 0, 1, 3, 0, "R9");   // recovers after drops

    for (int n = 0; n < 24; n++) begin
      int len;
      len = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1500, 1530))
                                        : int'($urandom_range(1, 300));
      sendFrame(len, 1, 1'($urandom_range(0, 1)), 0, 1, int'($urandom_range(0, 3)), 1, "R11");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule